// File: doc/BRIEF.md
# Machine-Level Timer with Prescaled Step Counter

The block keeps a 64-bit machine-time value that grows by a programmable increment each time a programmable clock divider wraps. It compares that value against a 64-bit match register and produces two interrupt outputs. The raw line goes straight to the core as its machine-timer interrupt. The second line goes to a peripheral interrupt controller, and it is qualified by an enable and by a sticky pending flag.

Software reaches the block through a plain 32-bit register port: a byte address, a write strobe, write data, and combinational read data. Every write completes in the cycle its strobe is high. The decoded window is 1 KiB. Address bits [1:0] are not decoded, because only whole-word accesses exist.

Register map (byte offsets):
- FAULT_FORCE at 0x000 is write-only and has no effect.
- RUN at 0x004: bit 0 is the run flag.
- TICKCFG at 0x100: the divider limit is in bits [11:0] and the increment is in bits [23:16].
- TIME_LO at 0x104 and TIME_HI at 0x108.
- MATCH_LO at 0x10C and MATCH_HI at 0x110.
- IRQ_EN at 0x114: bit 0 is the enable.
- IRQ_PEND at 0x118: bit 0 is the pending flag, write-1-to-clear.
- IRQ_FORCE at 0x11C: bit 0 forces the pending flag. This register is write-only.

Top module: `mtimer_core`

## Requirements
- R1: After reset:
  - RUN reads 0, TICKCFG reads 0x00010000 (divider 0, increment 1), and TIME_LO and TIME_HI read 0.
  - MATCH_LO and MATCH_HI read 0xFFFFFFFF, IRQ_EN and IRQ_PEND read 0.
  - Both interrupt outputs are low.
- R2: While RUN bit 0 is 1, a divider counts up from 0. On every clock edge where the divider is at or above the TICKCFG limit, it returns to 0 and the time value adds the increment. So with limit L the time value grows once every L+1 cycles. While RUN is 0, the divider and the time value hold.
- R3: A write to TIME_LO (0x104) or TIME_HI (0x108) loads only that 32-bit half, and no increment is applied in that cycle. A carry out of the low half during an increment propagates into the high half.
- R4: On each clock edge with RUN=1, irq_mtimer_o is updated to (MATCH <= TIME), using the full unsigned 64-bit values. While RUN=0, irq_mtimer_o holds its value and MATCH is not evaluated.
- R5: On a clock edge with RUN=1, MATCH <= TIME and IRQ_EN bit 0 = 1, IRQ_PEND bit 0 is set. When RUN=0, the match condition never sets IRQ_PEND.
- R6: Writing IRQ_PEND (0x118) with bit 0 = 1 clears the pending flag, unless a set condition occurs in the same cycle, in which case the set wins. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: Writing IRQ_FORCE (0x11C) with bit 0 = 1 sets IRQ_PEND bit 0 only if IRQ_EN bit 0 is 1. If IRQ_EN bit 0 is 0, the write leaves IRQ_PEND unchanged.
- R8: irq_periph_o follows (IRQ_PEND bit 0 AND IRQ_EN bit 0) one clock later. Clearing IRQ_EN drops the output but keeps the pending flag.
- R9: FAULT_FORCE (0x000), IRQ_FORCE (0x11C) and every unmapped offset read as 0. Writes to FAULT_FORCE or to unmapped offsets change no register.
- R10: Field positions and read-back masks are as follows:
  - RUN uses bit 0 only.
  - TICKCFG holds the divider in [11:0] and the increment in [23:16]; all other bits read 0.
  - IRQ_EN and IRQ_PEND use bit 0 only.
  - MATCH_LO and MATCH_HI read back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | AW (10) | Byte address of the access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for bus_addr_i, combinational |
| irq_mtimer_o | output | 1 | Raw machine-timer interrupt to the core |
| irq_periph_o | output | 1 | Enabled and pending peripheral interrupt |

## Verification
The assertions assume the following about the inputs:
- The write strobe is a clean single-cycle level.
- The address and data are stable across each clock edge.
- No write to the time value occurs in a cycle in which the frozen-counter property is checked.

The stimulus keeps to these assumptions by driving every bus input only on the falling clock edge and lowering the strobe after exactly one rising edge. For the same reason, the time value is preloaded only while RUN is 0, or while the increment is 0. The write-1-to-clear property relies on the enable being low, so that no set condition competes with the clear. The bench creates exactly that situation before it clears the flag.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

   // word indices (byte offset >> 2) of the register window
   localparam int unsigned WIX_FAULT_FORCE = 0;
   localparam int unsigned WIX_RUN         = 1;
   localparam int unsigned WIX_TICKCFG     = 64;
   localparam int unsigned WIX_TIME_LO     = 65;
   localparam int unsigned WIX_TIME_HI     = 66;
   localparam int unsigned WIX_MATCH_LO    = 67;
   localparam int unsigned WIX_MATCH_HI    = 68;
   localparam int unsigned WIX_IRQ_EN      = 69;
   localparam int unsigned WIX_IRQ_PEND    = 70;
   localparam int unsigned WIX_IRQ_FORCE   = 71;

   // increment field starts here inside TICKCFG
   localparam int unsigned STEP_LSB   = 16;
   localparam int unsigned STEP_RESET = 1;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_FAULT_FORCE,
      SEL_RUN,
      SEL_TICKCFG,
      SEL_TIME_LO,
      SEL_TIME_HI,
      SEL_MATCH_LO,
      SEL_MATCH_HI,
      SEL_IRQ_EN,
      SEL_IRQ_PEND,
      SEL_IRQ_FORCE
   } reg_sel_e;

endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
   import mtimer_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic [AW-1:0] addr_i,
   output reg_sel_e      sel_o
);
   localparam int unsigned IXW = AW - 2;

   logic [IXW-1:0] ix;
   assign ix = addr_i[AW-1:2];

   always_comb begin
      sel_o = SEL_NONE;
      case (ix)
         IXW'(WIX_FAULT_FORCE): sel_o = SEL_FAULT_FORCE;
         IXW'(WIX_RUN):         sel_o = SEL_RUN;
         IXW'(WIX_TICKCFG):     sel_o = SEL_TICKCFG;
         IXW'(WIX_TIME_LO):     sel_o = SEL_TIME_LO;
         IXW'(WIX_TIME_HI):     sel_o = SEL_TIME_HI;
         IXW'(WIX_MATCH_LO):    sel_o = SEL_MATCH_LO;
         IXW'(WIX_MATCH_HI):    sel_o = SEL_MATCH_HI;
         IXW'(WIX_IRQ_EN):      sel_o = SEL_IRQ_EN;
         IXW'(WIX_IRQ_PEND):    sel_o = SEL_IRQ_PEND;
         IXW'(WIX_IRQ_FORCE):   sel_o = SEL_IRQ_FORCE;
         default:               sel_o = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/mtimer_prescaler.sv
module mtimer_prescaler #(
   parameter int unsigned PRE_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [PRE_W-1:0] limit_i,
   output logic             tick_o
);
   logic [PRE_W-1:0] div_q;
   logic             wrap;

   // ">=" keeps the divider bounded when the limit is lowered mid-count
   assign wrap   = (div_q >= limit_i);
   assign tick_o = run_i & wrap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
      end else if (run_i) begin
         div_q <= wrap ? '0 : div_q + 1'b1;
      end
   end
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STEP_W = 8,
   parameter int unsigned NSEG   = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     tick_i,
   input  logic [STEP_W-1:0]        step_i,
   input  logic [NSEG-1:0]          seg_we_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [NSEG*DATA_W-1:0]   cnt_o
);
   localparam int unsigned CNT_W = NSEG * DATA_W;

   logic [DATA_W-1:0] seg_q [NSEG];
   logic [CNT_W-1:0]  sum;
   logic              adv;

   assign sum = cnt_o + CNT_W'(step_i);
   // a software load of any segment suppresses the increment that cycle
   assign adv = tick_i & ~(|seg_we_i);

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            seg_q[s] <= '0;
         end else if (seg_we_i[s]) begin
            seg_q[s] <= wdata_i;
         end else if (adv) begin
            seg_q[s] <= sum[s*DATA_W +: DATA_W];
         end
      end
      assign cnt_o[s*DATA_W +: DATA_W] = seg_q[s];
   end
endmodule

// File: rtl/mtimer_compare.sv
module mtimer_compare #(
   parameter int unsigned CNT_W     = 64,
   parameter bit          SPLIT_CMP = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] match_i,
   output logic             hit_o,
   output logic             raw_o
);
   localparam int unsigned HALF = CNT_W / 2;

   logic reached;

   if (SPLIT_CMP) begin : g_split
      // two half-width comparators instead of one full-width chain
      logic hi_gt, hi_eq, lo_ge;
      assign hi_gt   = cnt_i[CNT_W-1:HALF] >  match_i[CNT_W-1:HALF];
      assign hi_eq   = cnt_i[CNT_W-1:HALF] == match_i[CNT_W-1:HALF];
      assign lo_ge   = cnt_i[HALF-1:0]     >= match_i[HALF-1:0];
      assign reached = hi_gt | (hi_eq & lo_ge);
   end else begin : g_flat
      assign reached = (match_i <= cnt_i);
   end

   assign hit_o = run_i & reached;

   logic raw_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         raw_q <= 1'b0;
      end else if (run_i) begin
         raw_q <= reached;
      end
   end
   assign raw_o = raw_q;
endmodule

// File: rtl/mtimer_regfile.sv
module mtimer_regfile
   import mtimer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PRE_W  = 12,
   parameter int unsigned STEP_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  reg_sel_e            sel_i,
   input  logic                we_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [2*DATA_W-1:0] cnt_i,
   input  logic                hit_i,
   output logic                run_o,
   output logic [PRE_W-1:0]    limit_o,
   output logic [STEP_W-1:0]   step_o,
   output logic [2*DATA_W-1:0] match_o,
   output logic                en_o,
   output logic                pend_o,
   output logic                periph_o,
   output logic [1:0]          seg_we_o,
   output logic [DATA_W-1:0]   rdata_o
);
   localparam int unsigned CNT_W = 2 * DATA_W;

   logic               run_q, en_q, pend_q, periph_q;
   logic [PRE_W-1:0]   limit_q;
   logic [STEP_W-1:0]  step_q;
   logic [CNT_W-1:0]   match_q;
   logic               force_set, evt_set, pend_clr, pend_d;

   assign force_set = we_i && (sel_i == SEL_IRQ_FORCE) && wdata_i[0] && en_q;
   assign evt_set   = hit_i & en_q;
   assign pend_clr  = we_i && (sel_i == SEL_IRQ_PEND) && wdata_i[0];

   always_comb begin
      pend_d = pend_q;
      if (force_set || evt_set) begin
         pend_d = 1'b1;
      end else if (pend_clr) begin
         pend_d = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q    <= 1'b0;
         limit_q  <= '0;
         step_q   <= STEP_W'(STEP_RESET);
         match_q  <= '1;
         en_q     <= 1'b0;
         pend_q   <= 1'b0;
         periph_q <= 1'b0;
      end else begin
         if (we_i) begin
            case (sel_i)
               SEL_RUN:      run_q <= wdata_i[0];
               SEL_TICKCFG: begin
                  limit_q <= wdata_i[PRE_W-1:0];
                  step_q  <= wdata_i[STEP_LSB +: STEP_W];
               end
               SEL_MATCH_LO: match_q[DATA_W-1:0]     <= wdata_i;
               SEL_MATCH_HI: match_q[CNT_W-1:DATA_W] <= wdata_i;
               SEL_IRQ_EN:   en_q <= wdata_i[0];
               default: ;
            endcase
         end
         pend_q   <= pend_d;
         periph_q <= pend_q & en_q;
      end
   end

   assign seg_we_o[0] = we_i && (sel_i == SEL_TIME_LO);
   assign seg_we_o[1] = we_i && (sel_i == SEL_TIME_HI);

   always_comb begin
      rdata_o = '0;
      case (sel_i)
         SEL_RUN:      rdata_o[0] = run_q;
         SEL_TICKCFG: begin
            rdata_o[PRE_W-1:0]           = limit_q;
            rdata_o[STEP_LSB +: STEP_W]  = step_q;
         end
         SEL_TIME_LO:  rdata_o = cnt_i[DATA_W-1:0];
         SEL_TIME_HI:  rdata_o = cnt_i[CNT_W-1:DATA_W];
         SEL_MATCH_LO: rdata_o = match_q[DATA_W-1:0];
         SEL_MATCH_HI: rdata_o = match_q[CNT_W-1:DATA_W];
         SEL_IRQ_EN:   rdata_o[0] = en_q;
         SEL_IRQ_PEND: rdata_o[0] = pend_q;
         default: ;
      endcase
   end

   assign run_o    = run_q;
   assign limit_o  = limit_q;
   assign step_o   = step_q;
   assign match_o  = match_q;
   assign en_o     = en_q;
   assign pend_o   = pend_q;
   assign periph_o = periph_q;
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
   import mtimer_pkg::*;
#(
   parameter int unsigned AW        = 10,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned PRE_W     = 12,
   parameter int unsigned STEP_W    = 8,
   parameter bit          SPLIT_CMP = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [AW-1:0]     bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_mtimer_o,
   output logic              irq_periph_o
);
   localparam int unsigned NSEG  = 2;
   localparam int unsigned CNT_W = NSEG * DATA_W;

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data_w
      $error("mtimer_core: DATA_W must be 32");
   end
   if (AW < 9) begin : g_bad_aw
      $error("mtimer_core: AW too small for the register window");
   end
   if (PRE_W < 1 || PRE_W > STEP_LSB) begin : g_bad_pre_w
      $error("mtimer_core: PRE_W must lie in 1..16");
   end
   if (STEP_W < 1 || STEP_LSB + STEP_W > DATA_W) begin : g_bad_step_w
      $error("mtimer_core: STEP_W does not fit the config word");
   end

   reg_sel_e            sel;
   logic                run_w, en_w, pend_w, hit_w, tick_w;
   logic [PRE_W-1:0]    limit_w;
   logic [STEP_W-1:0]   step_w;
   logic [CNT_W-1:0]    match_w, cnt_w;
   logic [NSEG-1:0]     seg_we_w;

   mtimer_decode #(.AW(AW)) u_decode (
      .addr_i (bus_addr_i),
      .sel_o  (sel)
   );

   mtimer_regfile #(.DATA_W(DATA_W), .PRE_W(PRE_W), .STEP_W(STEP_W)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel),
      .we_i     (bus_we_i),
      .wdata_i  (bus_wdata_i),
      .cnt_i    (cnt_w),
      .hit_i    (hit_w),
      .run_o    (run_w),
      .limit_o  (limit_w),
      .step_o   (step_w),
      .match_o  (match_w),
      .en_o     (en_w),
      .pend_o   (pend_w),
      .periph_o (irq_periph_o),
      .seg_we_o (seg_we_w),
      .rdata_o  (bus_rdata_o)
   );

   mtimer_prescaler #(.PRE_W(PRE_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_w),
      .limit_i (limit_w),
      .tick_o  (tick_w)
   );

   mtimer_counter #(.DATA_W(DATA_W), .STEP_W(STEP_W), .NSEG(NSEG)) u_time (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_w),
      .step_i   (step_w),
      .seg_we_i (seg_we_w),
      .wdata_i  (bus_wdata_i),
      .cnt_o    (cnt_w)
   );

   mtimer_compare #(.CNT_W(CNT_W), .SPLIT_CMP(SPLIT_CMP)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run_w),
      .cnt_i   (cnt_w),
      .match_i (match_w),
      .hit_o   (hit_w),
      .raw_o   (irq_mtimer_o)
   );
endmodule

// File: rtl/mtimer_core_chk.sv
module mtimer_core_chk
   import mtimer_pkg::*;
#(
   parameter int unsigned AW     = 10,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 64
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [AW-1:0]     bus_addr_i,
   input logic              bus_we_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              run,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  match,
   input logic              en,
   input logic              pend,
   input logic              irq_mtimer_o,
   input logic              irq_periph_o
);
   localparam int unsigned IXW = AW - 2;

   logic [IXW-1:0] ix;
   logic           readable;
   assign ix       = bus_addr_i[AW-1:2];
   assign readable = (ix == IXW'(WIX_RUN)) ||
                     ((ix >= IXW'(WIX_TICKCFG)) && (ix <= IXW'(WIX_IRQ_PEND)));

   // R2: stopped timer with no bus write keeps its value
   p_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !bus_we_i) |=> $stable(cnt));

   // R4: running compare result reaches the raw line one edge later
   p_raw_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run |=> (irq_mtimer_o == $past(match <= cnt)));

   // R4: stopped timer holds the raw line
   p_raw_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> $stable(irq_mtimer_o));

   // R5 / R7: the pending flag only rises while enabled
   p_pend_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend) |-> $past(en));

   // R6: a one written to the pending register clears it when nothing can set it
   p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && ix == IXW'(WIX_IRQ_PEND) && bus_wdata_i[0] && !en) |=> !pend);

   // R8: peripheral line rises only after a pending flag existed
   p_periph_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_periph_o) |-> $past(pend));

   // R9: write-only and unmapped offsets return zero
   p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !readable |-> (bus_rdata_o == '0));
endmodule

bind mtimer_core mtimer_core_chk #(.AW(AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .bus_addr_i   (bus_addr_i),
   .bus_we_i     (bus_we_i),
   .bus_wdata_i  (bus_wdata_i),
   .bus_rdata_o  (bus_rdata_o),
   .run          (run_w),
   .cnt          (cnt_w),
   .match        (match_w),
   .en           (en_w),
   .pend         (pend_w),
   .irq_mtimer_o (irq_mtimer_o),
   .irq_periph_o (irq_periph_o)
);

// File: tb/mtimer_core_test.sv
module mtimer_core_test;
   localparam logic [9:0] A_FAULT = 10'h000, A_RUN = 10'h004, A_CFG = 10'h100,
                          A_TLO = 10'h104, A_THI = 10'h108, A_MLO = 10'h10C,
                          A_MHI = 10'h110, A_EN = 10'h114, A_PEND = 10'h118,
                          A_FORCE = 10'h11C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_m, irq_p;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   mtimer_core uut (
      .clk_i (clk), .rst_ni (rst_n), .bus_addr_i (addr), .bus_we_i (we),
      .bus_wdata_i (wdata), .bus_rdata_o (rdata),
      .irq_mtimer_o (irq_m), .irq_periph_o (irq_p)
   );

   // entry: {op (0 write, 1 read-compare), requirement number, address, data}
   localparam int NV = 25;
   localparam logic [47:0] VEC [NV] = '{
      {2'd1, 4'd1,  A_RUN,   32'h0000_0000},   // R1
      {2'd1, 4'd1,  A_CFG,   32'h0001_0000},   // R1
      {2'd1, 4'd1,  A_TLO,   32'h0000_0000},   // R1
      {2'd1, 4'd1,  A_THI,   32'h0000_0000},   // R1
      {2'd1, 4'd1,  A_MLO,   32'hFFFF_FFFF},   // R1
      {2'd1, 4'd1,  A_MHI,   32'hFFFF_FFFF},   // R1
      {2'd1, 4'd1,  A_EN,    32'h0000_0000},   // R1
      {2'd1, 4'd1,  A_PEND,  32'h0000_0000},   // R1
      {2'd0, 4'd10, A_CFG,   32'hFFFF_FFFF},   // R10
      {2'd1, 4'd10, A_CFG,   32'h00FF_0FFF},   // R10
      {2'd0, 4'd9,  A_FAULT, 32'hFFFF_FFFF},   // R9
      {2'd1, 4'd9,  A_FAULT, 32'h0000_0000},   // R9
      {2'd0, 4'd7,  A_FORCE, 32'h0000_0001},   // R7 enable is 0
      {2'd1, 4'd9,  A_FORCE, 32'h0000_0000},   // R9
      {2'd1, 4'd7,  A_PEND,  32'h0000_0000},   // R7
      {2'd0, 4'd9,  10'h200, 32'hFFFF_FFFF},   // R9
      {2'd1, 4'd9,  10'h200, 32'h0000_0000},   // R9
      {2'd1, 4'd9,  10'h3FC, 32'h0000_0000},   // R9
      {2'd1, 4'd9,  A_CFG,   32'h00FF_0FFF},   // R9 unmapped write ignored
      {2'd0, 4'd10, A_RUN,   32'hFFFF_FFFE},   // R10
      {2'd1, 4'd10, A_RUN,   32'h0000_0000},   // R10
      {2'd0, 4'd10, A_EN,    32'hFFFF_FFFF},   // R10
      {2'd1, 4'd10, A_EN,    32'h0000_0001},   // R10
      {2'd0, 4'd10, A_EN,    32'h0000_0000},   // R10
      {2'd0, 4'd10, A_MLO,   32'h1234_5678}    // R10
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all tasks are entered and left on a falling edge
   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] v);
      addr = a; we = 1'b0;
      #1 v = rdata;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 irq_mtimer_o", irq_m, 0);
      check("R1 irq_periph_o", irq_p, 0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][47:46] == 2'd0) begin
            wr(VEC[i][41:32], VEC[i][31:0]);
         end else begin
            rd(VEC[i][41:32], v);
            check($sformatf("R%0d table row %0d", VEC[i][45:42], i), v, VEC[i][31:0]);
         end
      end
      rd(A_MLO, v); check("R10 match low readback", v, 32'h1234_5678);

      // R2: divider limit 3, increment 5; run for 12 active edges -> 3 ticks
      wr(A_CFG, 32'h0005_0003);
      wr(A_MHI, 32'hFFFF_FFFF);
      wr(A_MLO, 32'hFFFF_FFFF);
      wr(A_RUN, 1);
      repeat (11) @(negedge clk);
      wr(A_RUN, 0);
      rd(A_TLO, v); check("R2 time after 12 running edges", v, 15);
      repeat (10) @(negedge clk);
      rd(A_TLO, v); check("R2 frozen while stopped", v, 15);

      // R3: carry from low into high half, one tick of 3
      wr(A_CFG, 32'h0003_0000);
      wr(A_TLO, 32'hFFFF_FFFE);
      wr(A_THI, 32'h0000_0012);
      wr(A_RUN, 1);
      wr(A_RUN, 0);
      rd(A_TLO, v); check("R3 low after carry", v, 1);
      rd(A_THI, v); check("R3 high after carry", v, 32'h13);
      wr(A_THI, 32'h55);
      rd(A_TLO, v); check("R3 low kept on high write", v, 1);
      rd(A_THI, v); check("R3 high loaded", v, 32'h55);

      // R4/R5: constant time (increment 0), match equal, enable set
      wr(A_CFG, 32'h0000_0000);
      wr(A_TLO, 32'h100);
      wr(A_THI, 0);
      wr(A_MHI, 0);
      wr(A_MLO, 32'h100);
      wr(A_EN, 1);
      repeat (3) @(negedge clk);
      check("R4 no raw irq while stopped", irq_m, 0);
      rd(A_PEND, v); check("R5 no pending while stopped", v, 0);
      wr(A_RUN, 1);
      check("R4 raw not before evaluation edge", irq_m, 0);
      @(negedge clk);
      check("R4 raw asserted on match", irq_m, 1);
      check("R8 periph one edge behind pending", irq_p, 0);
      @(negedge clk);
      check("R8 periph asserted", irq_p, 1);
      wr(A_EN, 0);
      check("R8 periph still high one edge", irq_p, 1);
      @(negedge clk);
      check("R8 periph masked by enable", irq_p, 0);
      rd(A_PEND, v); check("R5 pending set by match", v, 1);
      wr(A_PEND, 0);
      rd(A_PEND, v); check("R6 zero write keeps pending", v, 1);
      wr(A_PEND, 1);
      rd(A_PEND, v); check("R6 one write clears pending", v, 0);
      wr(A_FORCE, 1);
      rd(A_PEND, v); check("R7 force ignored when disabled", v, 0);

      // R4 hold: stop, move match above, raw stays high
      wr(A_RUN, 0);
      wr(A_MHI, 1);
      repeat (3) @(negedge clk);
      check("R4 raw holds while stopped", irq_m, 1);
      wr(A_RUN, 1);
      @(negedge clk);
      check("R4 raw drops below match", irq_m, 0);

      // R7: force while enabled
      wr(A_EN, 1);
      rd(A_PEND, v); check("R5 no pending below match", v, 0);
      wr(A_FORCE, 1);
      rd(A_PEND, v); check("R7 force sets pending", v, 1);
      check("R8 periph after force", irq_p, 1);
      wr(A_PEND, 1);
      rd(A_PEND, v); check("R6 clear after force", v, 0);

      // R4: 64-bit ordering, low half larger but high half smaller
      wr(A_EN, 0);
      wr(A_TLO, 32'hFFFF_FFFF);
      wr(A_MLO, 0);
      repeat (3) @(negedge clk);
      check("R4 0x0_FFFFFFFF below 0x1_00000000", irq_m, 0);
      wr(A_THI, 1);
      @(negedge clk);
      check("R4 0x1_FFFFFFFF reaches match", irq_m, 1);
      rd(A_PEND, v); check("R5 no pending when disabled", v, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule